// File: doc/BRIEF.md
# RMII Receive Nibble Assembler

This block sits on the receive side of a reduced-pin Ethernet PHY link. It takes the 2-bit receive symbols and the shared carrier/valid line from the PHY, one symbol per reference clock at 100 Mbps or one symbol per ten reference clocks at 10 Mbps. It hunts through the preamble for the start-of-frame delimiter and uses that delimiter to fix which symbol pairs form a nibble. It then delivers 4-bit nibbles to a MAC-facing receive port, each marked with a one-cycle strobe, a data-valid flag and an error flag.

PHY receive errors are forwarded on the nibble they arrive in. A reception that opens with the inverted preamble symbol is treated as a false carrier. No data is delivered for it, and when the activity ends the block reports it once with the standard false-carrier code. Recovering carrier sense from the shared line is left to a neighbouring block. Frame contents are not checked.

Top module: `rmii_rx_nibbler`

## Requirements
- R1: While and directly after reset, `nib_stb`, `nib_valid`, `nib_err` and `nib_data` are all zero and the block waits for a new reception.
- R2: Accepted symbols enter an 8-bit shift register at its top, so the oldest symbol sits in bits 1:0. No nibble with `nib_valid` = 1 is delivered until the register equals 0xD5, which is the symbol sequence 01, 01, 01, 11 with 11 last. A reception that never shows this sequence delivers no nibble.
- R3: With `slow_mode` = 0 the inputs are sampled on every clock. With `slow_mode` = 1 they are sampled on the first clock with `phy_crs_dv` high after idle and then on every 10th clock. Consecutive data nibbles are therefore 2 or 20 clocks apart.
- R4: After alignment, each pair of accepted symbols forms one nibble. The first symbol goes to bits 1:0 and the second to bits 3:2. The nibble is presented with `nib_stb` = 1 and `nib_valid` = 1 for one clock, starting on the clock after the second symbol is sampled.
- R5: If the first sampled symbol of a reception is 10, the reception is a false carrier. No data nibble is delivered, even if a delimiter follows. When the reception ends, one strobe is given with `nib_valid` = 0, `nib_err` = 1 and `nib_data` = 0xE.
- R6: A 10 symbol later in the preamble does not mark a false carrier. The delimiter hunt goes on, and the frame is delivered normally.
- R7: If `phy_rx_err` is high on a sample of either symbol of a data nibble, that nibble carries `nib_err` = 1. The other nibbles carry `nib_err` = 0.
- R8: A reception ends when `phy_crs_dv` is low on two consecutive sample points. A half-built nibble is then dropped. A single low sample point inside a frame does not end it, and the symbol on that sample point is not accepted.
- R9: On every clock without `nib_stb`, `nib_valid`, `nib_err` and `nib_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_mode | input | 1 | 1 selects the 10 Mbps sampling rate, 0 selects 100 Mbps |
| phy_dibit | input | 2 | Receive symbol from the PHY |
| phy_crs_dv | input | 1 | Shared carrier-sense / data-valid line from the PHY |
| phy_rx_err | input | 1 | Receive error from the PHY |
| nib_stb | output | 1 | One-clock strobe marking a delivered nibble or a false-carrier report |
| nib_data | output | 4 | Delivered nibble |
| nib_valid | output | 1 | Nibble carries frame data |
| nib_err | output | 1 | Nibble carries an error or the false-carrier report |

## Verification
Frames carry every nibble value 0 through F, plus a scrambled arithmetic sequence, at both sampling rates. This separates a wrong symbol order inside a nibble from a wrong sampling pace, which shows up as the strobe spacing. Preambles with a stray 10 symbol, with no delimiter, and with a leading 10 followed by a valid delimiter separate the delimiter hunt from the false-carrier decision. Odd trailing symbols, a single low sample inside data, and an error pulse on one nibble separate the end-of-frame rule from symbol skipping and from error propagation.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    // Alignment state of the receiver
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_DATA  = 2'd2,
        ST_FALSE = 2'd3
    } rx_state_e;

    localparam int SYM_W   = 2;
    localparam int NIB_W   = 4;
    localparam int SHIFT_W = 8;

    localparam logic [SHIFT_W-1:0] DELIM_BYTE  = 8'hD5;
    localparam logic [SYM_W-1:0]   BAD_SYMBOL  = 2'b10;
    localparam logic [NIB_W-1:0]   FALSE_CODE  = 4'hE;

    // Symbol accepted from the framer towards the packer
    typedef struct packed {
        logic             push;
        logic [SYM_W-1:0] sym;
        logic             err;
    } sym_beat_t;

    // Registered output beat
    typedef struct packed {
        logic             stb;
        logic [NIB_W-1:0] data;
        logic             valid;
        logic             err;
    } nib_beat_t;

    // New symbol enters at the top, oldest leaves from the bottom
    function automatic logic [SHIFT_W-1:0] shift_sym(
        input logic [SHIFT_W-1:0] cur,
        input logic [SYM_W-1:0]   sym
    );
        return {sym, cur[SHIFT_W-1:SYM_W]};
    endfunction

endpackage

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_mode,
    input  logic hold,
    output logic sample_en
);
    localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold || !slow_mode) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sample_en = !slow_mode || (cnt == '0);

endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
    import rmii_rx_pkg::*;
#(
    parameter int END_LOWS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic             crs_dv,
    input  logic [SYM_W-1:0] sym,
    input  logic             sym_err,
    output rx_state_e        state,
    output sym_beat_t        beat,
    output logic             aligned,
    output logic             fc_report
);
    localparam int LOW_W = (END_LOWS > 1) ? $clog2(END_LOWS) : 1;
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(END_LOWS - 1);

    rx_state_e          state_n;
    logic [SHIFT_W-1:0] shreg, shreg_n;
    logic [LOW_W-1:0]   lows, lows_n;

    always_comb begin
        state_n   = state;
        shreg_n   = shreg;
        lows_n    = lows;
        beat      = '0;
        aligned   = 1'b0;
        fc_report = 1'b0;
        if (sample_en) begin
            if (crs_dv) begin
                lows_n = '0;
                unique case (state)
                    ST_IDLE: begin
                        if (sym == BAD_SYMBOL) begin
                            state_n = ST_FALSE;
                        end else begin
                            shreg_n = shift_sym(shreg, sym);
                            state_n = ST_HUNT;
                        end
                    end
                    ST_HUNT: begin
                        shreg_n = shift_sym(shreg, sym);
                        if (shreg_n == DELIM_BYTE) begin
                            state_n = ST_DATA;
                            aligned = 1'b1;
                        end
                    end
                    ST_DATA: begin
                        beat.push = 1'b1;
                        beat.sym  = sym;
                        beat.err  = sym_err;
                    end
                    default: ;
                endcase
            end else if (state != ST_IDLE) begin
                if (lows == LOW_LAST) begin
                    state_n   = ST_IDLE;
                    shreg_n   = '0;
                    lows_n    = '0;
                    fc_report = (state == ST_FALSE);
                end else begin
                    lows_n = lows + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            lows  <= '0;
        end else begin
            state <= state_n;
            shreg <= shreg_n;
            lows  <= lows_n;
        end
    end

endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer
    import rmii_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sym_beat_t beat,
    input  logic      aligned,
    input  logic      fc_report,
    output nib_beat_t out
);
    logic             half;
    logic [SYM_W-1:0] low_sym;
    logic             low_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            half    <= 1'b0;
            low_sym <= '0;
            low_err <= 1'b0;
            out     <= '0;
        end else begin
            out <= '0;
            if (fc_report) begin
                out.stb   <= 1'b1;
                out.data  <= FALSE_CODE;
                out.err   <= 1'b1;
                out.valid <= 1'b0;
                half      <= 1'b0;
            end else if (aligned) begin
                half <= 1'b0;
            end else if (beat.push) begin
                if (!half) begin
                    low_sym <= beat.sym;
                    low_err <= beat.err;
                    half    <= 1'b1;
                end else begin
                    out.stb   <= 1'b1;
                    out.valid <= 1'b1;
                    out.data  <= {beat.sym, low_sym};
                    out.err   <= low_err | beat.err;
                    half      <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rmii_rx_nibbler.sv
module rmii_rx_nibbler
    import rmii_rx_pkg::*;
#(
    parameter int SLOW_DIV = 10,
    parameter int END_LOWS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_mode,
    input  logic [1:0] phy_dibit,
    input  logic       phy_crs_dv,
    input  logic       phy_rx_err,
    output logic       nib_stb,
    output logic [3:0] nib_data,
    output logic       nib_valid,
    output logic       nib_err
);
    logic      sample_en;
    logic      aligned;
    logic      fc_report;
    rx_state_e fsm_state;
    sym_beat_t beat;
    nib_beat_t outb;

    rmii_rx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .slow_mode (slow_mode),
        .hold      ((fsm_state == ST_IDLE) && !phy_crs_dv),
        .sample_en (sample_en)
    );

    rmii_rx_framer #(.END_LOWS(END_LOWS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .crs_dv    (phy_crs_dv),
        .sym       (phy_dibit),
        .sym_err   (phy_rx_err),
        .state     (fsm_state),
        .beat      (beat),
        .aligned   (aligned),
        .fc_report (fc_report)
    );

    rmii_rx_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .aligned   (aligned),
        .fc_report (fc_report),
        .out       (outb)
    );

    assign nib_stb   = outb.stb;
    assign nib_data  = outb.data;
    assign nib_valid = outb.valid;
    assign nib_err   = outb.err;

endmodule

// File: rtl/rmii_rx_nibbler_chk.sv
module rmii_rx_nibbler_chk
    import rmii_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       slow_mode,
    input logic       nib_stb,
    input logic [3:0] nib_data,
    input logic       nib_valid,
    input logic       nib_err,
    input rx_state_e  fsm_state
);
    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !nib_stb |-> (!nib_valid && !nib_err && nib_data == 4'h0)); // R9

    AST_DATA_NEEDS_DELIM: assert property (@(posedge clk) disable iff (rst)
        nib_valid |-> ($past(fsm_state) == ST_DATA)); // R2

    AST_FALSE_CODE: assert property (@(posedge clk) disable iff (rst)
        (nib_stb && !nib_valid) |-> (nib_err && nib_data == FALSE_CODE)); // R5

    AST_FALSE_FROM_FALSE_STATE: assert property (@(posedge clk) disable iff (rst)
        (nib_stb && !nib_valid) |-> ($past(fsm_state) == ST_FALSE)); // R5

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        nib_stb |=> !nib_stb); // R4

    AST_SLOW_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        (slow_mode && nib_stb) |=> !nib_stb); // R3

endmodule

bind rmii_rx_nibbler rmii_rx_nibbler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .slow_mode (slow_mode),
    .nib_stb   (nib_stb),
    .nib_data  (nib_data),
    .nib_valid (nib_valid),
    .nib_err   (nib_err),
    .fsm_state (fsm_state)
);

// File: tb/rmii_rx_nibbler_test.sv
`timescale 1ns/1ps
module rmii_rx_nibbler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_mode = 1'b0;
    logic [1:0] phy_dibit = 2'b00;
    logic       phy_crs_dv = 1'b0;
    logic       phy_rx_err = 1'b0;
    logic       nib_stb;
    logic [3:0] nib_data;
    logic       nib_valid;
    logic       nib_err;

    rmii_rx_nibbler uut (
        .clk(clk), .rst(rst), .slow_mode(slow_mode),
        .phy_dibit(phy_dibit), .phy_crs_dv(phy_crs_dv), .phy_rx_err(phy_rx_err),
        .nib_stb(nib_stb), .nib_data(nib_data), .nib_valid(nib_valid), .nib_err(nib_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [3:0] got_d [64];
    logic       got_v [64];
    logic       got_e [64];
    int         got_c [64];
    int         got_n = 0;
    int         quiet_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (nib_stb) begin
                if (got_n < 64) begin
                    got_d[got_n] = nib_data;
                    got_v[got_n] = nib_valid;
                    got_e[got_n] = nib_err;
                    got_c[got_n] = cyc;
                end
                got_n = got_n + 1;
            end else if (nib_valid || nib_err || nib_data != 4'h0) begin
                quiet_bad = quiet_bad + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per();
        return slow_mode ? 10 : 1;
    endfunction

    task automatic put(input logic [1:0] d, input logic dv, input logic er);
        phy_dibit  = d;
        phy_crs_dv = dv;
        phy_rx_err = er;
        repeat (per()) @(negedge clk);
    endtask

    task automatic preamble();
        for (int i = 0; i < 6; i++) put(2'b01, 1'b1, 1'b0);
        put(2'b11, 1'b1, 1'b0);
    endtask

    task automatic nibble(input logic [3:0] v, input bit er2);
        put(v[1:0], 1'b1, 1'b0);
        put(v[3:2], 1'b1, er2);
    endtask

    task automatic gap();
        for (int i = 0; i < 4; i++) put(2'b00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [3:0] pat(input int kind, input int i);
        return (kind == 0) ? 4'(i) : 4'((i * 7 + 3) % 16);
    endfunction

    // Sends a frame of n nibbles of the given pattern and checks it
    task automatic data_frame(input int kind, input int n, input string req);
        int bad = 0;
        int gapbad = 0;
        got_n = 0;
        preamble();
        for (int i = 0; i < n; i++) nibble(pat(kind, i), 1'b0);
        gap();
        check(got_n == n, req, got_n, n);
        for (int i = 0; i < n && i < got_n; i++) begin
            if (got_d[i] != pat(kind, i) || !got_v[i] || got_e[i]) bad = bad + 1;
            if (i > 0 && got_c[i] - got_c[i-1] != 2 * per()) gapbad = gapbad + 1;
        end
        check(bad == 0, "R4 nibble order and value", bad, 0);
        check(gapbad == 0, "R3 strobe spacing", gapbad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!nib_stb && !nib_valid && !nib_err && nib_data == 4'h0, "R1 outputs in reset",
              {nib_stb, nib_valid, nib_err, nib_data}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(got_n == 0 && !nib_stb, "R1 idle after reset", got_n, 0);

        // R2, R3, R4: both patterns at both rates
        for (int m = 0; m < 2; m++) begin
            slow_mode = 1'(m);
            for (int k = 0; k < 2; k++) data_frame(k, 16, "R2 R3 nibble count");
        end
        slow_mode = 1'b0;

        // R2: preamble only, never a delimiter
        got_n = 0;
        for (int i = 0; i < 20; i++) put(2'b01, 1'b1, 1'b0);
        gap();
        check(got_n == 0, "R2 no delimiter no output", got_n, 0);

        // R5: false carrier at both rates, with a delimiter inside
        for (int m = 0; m < 2; m++) begin
            slow_mode = 1'(m);
            got_n = 0;
            put(2'b10, 1'b1, 1'b0);
            for (int i = 0; i < 5; i++) put(2'b10, 1'b1, 1'b0);
            preamble();
            for (int i = 0; i < 3; i++) nibble(4'hA, 1'b0);
            gap();
            check(got_n == 1, "R5 false carrier single report", got_n, 1);
            check(got_n >= 1 && !got_v[0] && got_e[0] && got_d[0] == 4'hE,
                  "R5 false carrier code", {got_v[0], got_e[0], got_d[0]}, 6'b01_1110);
        end
        slow_mode = 1'b0;

        // R6: stray 10 inside the preamble
        got_n = 0;
        put(2'b01, 1'b1, 1'b0);
        put(2'b10, 1'b1, 1'b0);
        preamble();
        nibble(4'h9, 1'b0);
        nibble(4'h6, 1'b0);
        gap();
        check(got_n == 2 && got_d[0] == 4'h9 && got_d[1] == 4'h6 && got_v[0] && got_v[1],
              "R6 late 10 symbol ignored", got_n, 2);

        // R7: receive error on the second symbol of nibble 5
        got_n = 0;
        preamble();
        for (int i = 0; i < 8; i++) nibble(pat(1, i), i == 5);
        gap();
        begin
            int bad = 0;
            for (int i = 0; i < 8 && i < got_n; i++)
                if (got_e[i] != (i == 5) || got_d[i] != pat(1, i) || !got_v[i]) bad = bad + 1;
            check(got_n == 8 && bad == 0, "R7 error on nibble 5 only", bad, 0);
        end

        // R8: trailing half nibble dropped
        got_n = 0;
        preamble();
        for (int i = 0; i < 3; i++) nibble(pat(0, i + 4), 1'b0);
        put(2'b11, 1'b1, 1'b0);
        gap();
        check(got_n == 3, "R8 half nibble dropped", got_n, 3);
        // the next frame must start cleanly aligned
        got_n = 0;
        preamble();
        nibble(4'h3, 1'b0);
        gap();
        check(got_n == 1 && got_d[0] == 4'h3, "R8 next frame aligned", got_d[0], 3);

        // R8: single low sample inside data, at both rates
        for (int m = 0; m < 2; m++) begin
            slow_mode = 1'(m);
            got_n = 0;
            preamble();
            nibble(4'hC, 1'b0);
            put(2'b11, 1'b0, 1'b0);
            nibble(4'h5, 1'b0);
            gap();
            check(got_n == 2 && got_d[0] == 4'hC && got_d[1] == 4'h5,
                  "R8 single low sample skipped", got_n > 1 ? got_d[1] : -1, 5);
        end
        slow_mode = 1'b0;

        // R1: reset in the middle of a frame
        got_n = 0;
        preamble();
        put(2'b10, 1'b1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check(!nib_stb && !nib_valid, "R1 reset mid frame", nib_stb, 0);
        phy_crs_dv = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        got_n = 0;
        preamble();
        nibble(4'h7, 1'b0);
        gap();
        check(got_n == 1 && got_d[0] == 4'h7, "R1 clean after reset", got_d[0], 7);

        check(quiet_bad == 0, "R9 quiet outputs without strobe", quiet_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule